// File: doc/BRIEF.md
# Packed SIMD Narrowing Pack Unit

This block takes two 64-bit operand vectors and narrows every element of both to half its width. The narrowed elements of the first operand fill the lower half of the result in lane order, and those of the second operand fill the upper half. A two-bit width select picks one of three narrowings: 16 to 8 bits, 32 to 16 bits, or 64 to 32 bits. Each narrowing keeps only the low bits of every element; no saturation is applied.

Alongside the result the block produces a 32-bit status word. It holds one 4-bit field per result byte. Every narrowed output lane reports a negative flag and a zero flag. A signed/unsigned select is present on the interface so that saturation can be added later. In this version it has no effect on any output.

The datapath is combinational. A parameter adds an output register, which is present by default and gives the block one cycle of latency.

Top module: `simd_pack_narrow`

## Requirements
- R1: With `width_sel_i` = 0 (16 to 8), result byte k for k = 0..3 equals bits [16k+7:16k] of `src_a_i`, and result byte 4+k equals bits [16k+7:16k] of `src_b_i`.
- R2: With `width_sel_i` = 1 (32 to 16), result halfword k for k = 0..1 equals bits [32k+15:32k] of `src_a_i`, and result halfword 2+k equals bits [32k+15:32k] of `src_b_i`.
- R3: With `width_sel_i` = 2 (64 to 32), result bits [31:0] equal `src_a_i[31:0]` and result bits [63:32] equal `src_b_i[31:0]`.
- R4: `signed_i` has no effect: for the same operands and width select, the result and the status word are identical whichever value it takes.
- R5: The status word holds one 4-bit field per result byte, with field n at bits [4n+3:4n]. Within a flagged field, bit 3 is the lane's most significant bit (negative) and bit 2 is set when every bit of the lane is zero. Bits 1:0 of every field are always 0.
- R6: In 16-to-8 mode all eight fields carry flags. In 32-to-16 mode only fields 1, 3, 5 and 7 carry flags, and in 64-to-32 mode only fields 3 and 7 do. Each of those fields belongs to the most significant byte of its lane, and every other field reads 0.
- R7: With `OUT_REG` = 1 (the default), the result and the status word appear one clock after the inputs are sampled, and an active-low reset clears both to zero.
- R8: `width_sel_i` = 3 behaves exactly as 64-to-32 mode, for both the data and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| width_sel_i | input | 2 | Narrowing: 0 = 16 to 8, 1 = 32 to 16, 2 or 3 = 64 to 32 |
| signed_i | input | 1 | Signed/unsigned select, reserved for saturation, no effect |
| src_a_i | input | 64 | First operand, fills the lower half of the result |
| src_b_i | input | 64 | Second operand, fills the upper half of the result |
| result_o | output | 64 | Packed narrowed result |
| status_o | output | 32 | Per-lane negative/zero flags, 4 bits per result byte |

## Verification
Operands in which every byte holds its own index show where each source byte lands, so a swapped lane or a wrong half shows up at once. All-zero operands, and operands in which only the discarded upper bits are set, exercise the zero flags and show that the high bits of each element are dropped. Sign-bit patterns such as 0x80 and 0x8000 in the kept bits exercise the negative flag at each lane width. A stream of pseudo-random operands covers all four width codes with `signed_i` toggled, and each cycle is compared against a bit-level reference model. That comparison separates the modes, the flag placement of each mode and the one-cycle latency.

// File: rtl/pack_pkg.sv
package pack_pkg;

    localparam int VEC_W  = 64;
    localparam int STAT_W = VEC_W / 2;

    typedef enum logic [1:0] {
        NARROW_H2B = 2'd0,
        NARROW_W2H = 2'd1,
        NARROW_D2W = 2'd2,
        NARROW_RSV = 2'd3
    } narrow_e;

    typedef struct packed {
        logic [VEC_W-1:0]  data;
        logic [STAT_W-1:0] stat;
    } pack_out_t;

endpackage

// File: rtl/pack_lane_sel.sv
module pack_lane_sel
    import pack_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  narrow_e           mode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] packed_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam int N_H    = DATA_W / 16;
    localparam int N_W    = DATA_W / 32;

    logic [DATA_W-1:0] h2b_d, w2h_d, d2w_d;

    always_comb begin
        h2b_d = '0;
        w2h_d = '0;
        for (int k = 0; k < N_H; k++) begin
            h2b_d[8*k +: 8]          = a_i[16*k +: 8];
            h2b_d[HALF_W + 8*k +: 8] = b_i[16*k +: 8];
        end
        for (int k = 0; k < N_W; k++) begin
            w2h_d[16*k +: 16]          = a_i[32*k +: 16];
            w2h_d[HALF_W + 16*k +: 16] = b_i[32*k +: 16];
        end
        d2w_d = {b_i[HALF_W-1:0], a_i[HALF_W-1:0]};
    end

    always_comb begin
        unique case (mode_i)
            NARROW_H2B: packed_o = h2b_d;
            NARROW_W2H: packed_o = w2h_d;
            default:    packed_o = d2w_d;
        endcase
    end

endmodule

// File: rtl/pack_flag_gen.sv
module pack_flag_gen
    import pack_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  narrow_e             mode_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [DATA_W/2-1:0] stat_o
);

    localparam int N_B = DATA_W / 8;
    localparam int N_H = DATA_W / 16;
    localparam int N_W = DATA_W / 32;

    always_comb begin
        stat_o = '0;
        unique case (mode_i)
            NARROW_H2B: begin
                for (int l = 0; l < N_B; l++) begin
                    stat_o[4*l + 3] = data_i[8*l + 7];
                    stat_o[4*l + 2] = (data_i[8*l +: 8] == '0);
                end
            end
            NARROW_W2H: begin
                for (int l = 0; l < N_H; l++) begin
                    stat_o[4*(2*l + 1) + 3] = data_i[16*l + 15];
                    stat_o[4*(2*l + 1) + 2] = (data_i[16*l +: 16] == '0);
                end
            end
            default: begin
                for (int l = 0; l < N_W; l++) begin
                    stat_o[4*(4*l + 3) + 3] = data_i[32*l + 31];
                    stat_o[4*(4*l + 3) + 2] = (data_i[32*l +: 32] == '0);
                end
            end
        endcase
    end

endmodule

// File: rtl/simd_pack_narrow.sv
module simd_pack_narrow
    import pack_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        width_sel_i,
    input  logic              signed_i,
    input  logic [VEC_W-1:0]  src_a_i,
    input  logic [VEC_W-1:0]  src_b_i,
    output logic [VEC_W-1:0]  result_o,
    output logic [STAT_W-1:0] status_o
);

    narrow_e           mode;
    logic [VEC_W-1:0]  packed_w;
    logic [STAT_W-1:0] stat_w;
    pack_out_t         out_d, out_q;

    assign mode = narrow_e'(width_sel_i);

    pack_lane_sel #(.DATA_W(VEC_W)) i_lane_sel (
        .mode_i   (mode),
        .a_i      (src_a_i),
        .b_i      (src_b_i),
        .packed_o (packed_w)
    );

    pack_flag_gen #(.DATA_W(VEC_W)) i_flag_gen (
        .mode_i (mode),
        .data_i (packed_w),
        .stat_o (stat_w)
    );

    always_comb begin
        out_d      = '0;
        out_d.data = packed_w;
        out_d.stat = stat_w;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) out_q <= '0;
                else         out_q <= out_d;
            end
            assign result_o = out_q.data;
            assign status_o = out_q.stat;

            // R1
            h2b_low_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (width_sel_i == 2'd0) |=>
                    (result_o[15:8] == $past(src_a_i[23:16]) &&
                     result_o[63:56] == $past(src_b_i[55:48])));

            // R2
            w2h_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (width_sel_i == 2'd1) |=>
                    (result_o[31:16] == $past(src_a_i[47:32]) &&
                     result_o[47:32] == $past(src_b_i[15:0])));

            // R3
            d2w_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (width_sel_i[1]) |=>
                    (result_o == {$past(src_b_i[31:0]), $past(src_a_i[31:0])}));

            // R4
            sign_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && signed_i != $past(signed_i) &&
                 src_a_i == $past(src_a_i) && src_b_i == $past(src_b_i) &&
                 width_sel_i == $past(width_sel_i)) |=>
                    ($stable(result_o) && $stable(status_o)));

            // R5
            top_neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                status_o[31] == result_o[63]);

            // R5
            spare_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (status_o & 32'h3333_3333) == 32'h0);
        end else begin : g_comb
            assign out_q    = out_d;
            assign result_o = out_q.data;
            assign status_o = out_q.stat;
            wire unused_ok = &{1'b0, clk_i, rst_ni, signed_i};
        end
    endgenerate

endmodule

// File: tb/test_simd_pack_narrow.sv
module test_simd_pack_narrow;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  width_sel = '0;
    logic        sgn = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_pack_narrow i_simd_pack_narrow (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .width_sel_i (width_sel),
        .signed_i    (sgn),
        .src_a_i     (src_a),
        .src_b_i     (src_b),
        .result_o    (result),
        .status_o    (status)
    );

    function automatic int lane_bits(input logic [1:0] m);
        if (m == 2'd0) return 8;
        if (m == 2'd1) return 16;
        return 32;
    endfunction

    function automatic logic [63:0] ref_data(input logic [1:0] m,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
        int w = lane_bits(m);
        int per_half = 32 / w;
        logic [63:0] r = '0;
        for (int j = 0; j < 64; j++) begin
            int lane = j / w;
            int src_idx = (lane % per_half) * 2 * w + (j % w);
            r[j] = (lane < per_half) ? a[src_idx] : b[src_idx];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_stat(input logic [1:0] m,
                                             input logic [63:0] r);
        int w = lane_bits(m);
        logic [31:0] s = '0;
        for (int l = 0; l < 64 / w; l++) begin
            int nib = (l + 1) * (w / 8) - 1;
            bit z = 1'b1;
            for (int i = 0; i < w; i++) if (r[l*w + i]) z = 1'b0;
            s[4*nib + 3] = r[l*w + w - 1];
            s[4*nib + 2] = z;
        end
        return s;
    endfunction

    task automatic check_out(input string req, input logic [63:0] exp_d,
                             input logic [31:0] exp_s);
        checks++;
        if (result !== exp_d) begin
            errors++;
            $display("FAIL %s data: actual=%h expected=%h", req, result, exp_d);
        end
        checks++;
        if (status !== exp_s) begin
            errors++;
            $display("FAIL %s flags: actual=%h expected=%h", req, status, exp_s);
        end
    endtask

    // drive on falling edge, captured at next rising edge, compared at the following falling edge
    task automatic apply(input string req, input logic [1:0] m, input logic s,
                         input logic [63:0] a, input logic [63:0] b);
        logic [63:0] ed;
        width_sel = m; sgn = s; src_a = a; src_b = b;
        ed = ref_data(m, a, b);
        @(negedge clk);
        check_out(req, ed, ref_stat(m, ed));
    endtask

    initial begin
        logic [63:0] lfsr;
        logic [63:0] ra, rb;
        logic [63:0] keep_d;
        logic [31:0] keep_s;
        @(negedge clk);
        @(negedge clk);
        check_out("R7 reset", 64'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        apply("R1 index", 2'd0, 1'b0, 64'h0706_0504_0302_0100, 64'h0f0e_0d0c_0b0a_0908);
        apply("R2 index", 2'd1, 1'b0, 64'h0706_0504_0302_0100, 64'h0f0e_0d0c_0b0a_0908);
        apply("R3 index", 2'd2, 1'b0, 64'h0706_0504_0302_0100, 64'h0f0e_0d0c_0b0a_0908);
        apply("R8 index", 2'd3, 1'b1, 64'h0706_0504_0302_0100, 64'h0f0e_0d0c_0b0a_0908);
        apply("R5 R1 zero", 2'd0, 1'b0, 64'h0, 64'h0);
        apply("R6 R2 zero", 2'd1, 1'b0, 64'h0, 64'h0);
        apply("R6 R3 zero", 2'd2, 1'b0, 64'h0, 64'h0);
        apply("R1 drop high", 2'd0, 1'b1, 64'hff00_ff00_ff00_ff00, 64'hab00_cd00_ef00_1200);
        apply("R2 drop high", 2'd1, 1'b1, 64'hffff_0000_1234_0000, 64'h8000_0000_0000_0000);
        apply("R5 R1 neg", 2'd0, 1'b0, 64'h0080_007f_0080_0001, 64'h00ff_0000_0080_0080);
        apply("R6 R2 neg", 2'd1, 1'b0, 64'h0000_8000_0000_7fff, 64'h0000_0000_0000_8001);
        apply("R6 R3 neg", 2'd2, 1'b0, 64'h0000_0000_8000_0000, 64'h7fff_ffff_0000_0000);

        // R4: same operands, sign select toggled, outputs must not move
        ra = 64'h8123_4567_89ab_cdef; rb = 64'hfedc_ba98_7654_3210;
        for (int m = 0; m < 4; m++) begin
            apply("R4 sign=0", 2'(m), 1'b0, ra, rb);
            keep_d = result; keep_s = status;
            apply("R4 sign=1", 2'(m), 1'b1, ra, rb);
            check_out("R4 toggle", keep_d, keep_s);
        end

        lfsr = 64'hace1_2468_bdf1_3579;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            ra = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            rb = (n % 7 == 0) ? (lfsr & 64'hff00_ff00_ffff_0000) : lfsr;
            apply("R1 R2 R3 R8 random", lfsr[5:4], lfsr[9], ra, rb);
        end

        // R7: reset in mid-stream clears the outputs
        rst_n = 1'b0;
        #1;
        check_out("R7 async reset", 64'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule